// File: doc/BRIEF.md
# Band-Switched DDS Tuning Controller

This block takes a commanded output frequency in hertz, converts it into a 32-bit frequency tuning word for a direct digital synthesizer, and ships that word out as a serial write frame. It also chooses the synthesizer's reference clock setting from the band that the frequency falls in. Each band has its own reference multiplier, so spurious products land away from the tuned frequency. The band follows the command only once the command has moved clearly outside the current band, by a hysteresis margin. Small back-and-forth tuning near a band edge therefore never triggers a reference change.

When the band changes, the new reference setting is presented at once. The tuning word is held back for a settling interval, so that the word is only written once the new clock is stable. Commands that arrive while the block is settling or transmitting are kept, and only the newest one is applied. A tuning change that stays inside the current band is sent without a wait. A busy output covers the whole span from accepting a command until its frame has gone out.

Top module: `dds_tune_ctrl`

## Requirements
- R1: After synchronous reset, busy is 0, spi_cs_n is 1, spi_sclk is 0, ref_band is 0 and ref_mult equals MULT_EVEN.
- R2: When the band changes, the new band is floor(f / BAND_STEP_HZ), clamped to F_MAX_HZ / BAND_STEP_HZ.
- R3: With current band b, the band does not change while b*BAND_STEP_HZ - HYST_HZ <= f < (b+1)*BAND_STEP_HZ + HYST_HZ.
- R4: ref_mult is MULT_EVEN for even ref_band values and MULT_ODD for odd values. The synthesizer system clock is REF_HZ * ref_mult.
- R5: The tuning word is floor((f*K + 2^29) / 2^30) mod 2^32, where K = floor((2^62 + sys/2) / sys) and sys is the system clock of the band in force.
- R6: Each frame holds spi_cs_n low for exactly 40 bits, sent MSB first: the byte INSTR followed by the 32-bit tuning word. The bits use SPI mode 0, so spi_sclk idles low and spi_mosi changes only while spi_sclk is low.
- R7: A command that keeps the band is followed by spi_cs_n falling 2 clock edges after the edge that accepts the command.
- R8: A command that changes the band updates ref_band one edge after acceptance. spi_cs_n then falls SETTLE_CYCLES + 3 edges after acceptance, and it stays high throughout the settle interval.
- R9: Commands accepted during a settle interval replace the held command, and only the newest is sent, in one frame.
- R10: busy is 1 from the edge after a command is accepted until the last frame caused by it has ended.
- R11: A command accepted while a frame is being sent does not cut that frame short. It is sent in its own frame afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_freq | input | FREQ_W | Commanded output frequency in Hz |
| busy | output | 1 | Command pending, settling or transmitting |
| ref_band | output | BAND_W | Selected frequency band |
| ref_mult | output | 8 | Reference multiplier for the selected band |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data, MSB first |
| spi_cs_n | output | 1 | Active-low frame select |

## Verification
A wrong band register shows up in two ways: ref_band or ref_mult will be wrong one edge after the command, and the tuning word in the next frame will be scaled by the wrong system clock. Both are visible within one frame. A fault in the settle counter or the pending-command flag changes the exact edge on which spi_cs_n falls, or changes how many frames go out. The bench measures both for every command. A corrupted shift register or divider shows up at once as a wrong 40-bit frame, or as a frame of the wrong length.

// File: rtl/dds_tune_pkg.sv
package dds_tune_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_SEND   = 2'd2
    } ctl_state_t;

    typedef struct packed {
        logic [7:0]  instr;
        logic [31:0] ftw;
    } spi_frame_t;

    localparam int FRAME_BITS = $bits(spi_frame_t);

    // Rounded fixed-point reciprocal: 2^62 / sys_hz
    function automatic logic [63:0] recip_q62(input longint unsigned sys_hz);
        longint unsigned num;
        num = (64'd1 << 62) + (sys_hz >> 1);
        return num / sys_hz;
    endfunction

endpackage

// File: rtl/dds_band_sel.sv
module dds_band_sel #(
    parameter int FREQ_W    = 28,
    parameter int BAND_W    = 6,
    parameter int NBANDS    = 51,
    parameter int STEP_HZ   = 4_000_000,
    parameter int HYST_HZ   = 1_000_000
) (
    input  logic [FREQ_W-1:0] freq,
    input  logic [BAND_W-1:0] cur_band,
    output logic [BAND_W-1:0] nxt_band,
    output logic              change
);
    localparam logic [39:0] STEP_L = 40'(STEP_HZ);
    localparam logic [39:0] HYST_L = 40'(HYST_HZ);
    localparam logic [39:0] TOP_L  = 40'(NBANDS - 1);

    logic [39:0] f_e, lo, hi, raw;
    logic        leave;

    always_comb begin
        f_e      = 40'(freq);
        lo       = 40'(cur_band) * STEP_L;
        hi       = lo + STEP_L + HYST_L;
        leave    = ((f_e + HYST_L) < lo) || (f_e >= hi);
        raw      = f_e / STEP_L;
        nxt_band = (raw > TOP_L) ? BAND_W'(TOP_L) : BAND_W'(raw);
        change   = leave && (nxt_band != cur_band);
    end
endmodule

// File: rtl/dds_ftw_calc.sv
module dds_ftw_calc
    import dds_tune_pkg::*;
#(
    parameter int FREQ_W    = 28,
    parameter int REF_HZ    = 20_000_000,
    parameter int MULT_EVEN = 20,
    parameter int MULT_ODD  = 19
) (
    input  logic [FREQ_W-1:0] freq,
    input  logic              odd_band,
    output logic [31:0]       ftw
);
    localparam logic [63:0] K_EVEN = recip_q62(64'(REF_HZ) * 64'(MULT_EVEN));
    localparam logic [63:0] K_ODD  = recip_q62(64'(REF_HZ) * 64'(MULT_ODD));
    localparam logic [63:0] HALF_LSB = 64'd1 << 29;

    logic [63:0] k_sel, prod;

    always_comb begin
        k_sel = odd_band ? K_ODD : K_EVEN;
        prod  = 64'(freq) * k_sel + HALF_LSB;
        ftw   = prod[61:30];
    end
endmodule

// File: rtl/dds_spi_tx.sv
module dds_spi_tx
    import dds_tune_pkg::*;
#(
    parameter int SCLK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  spi_frame_t frame,
    output logic       active,
    output logic       sclk,
    output logic       mosi,
    output logic       cs_n
);
    localparam int DIV_W  = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam int NHALF  = 2 * FRAME_BITS;
    localparam int HALF_W = $clog2(NHALF);

    logic [FRAME_BITS-1:0] sh_q;
    logic [DIV_W-1:0]      div_q;
    logic [HALF_W-1:0]     half_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            sh_q   <= '0;
            div_q  <= '0;
            half_q <= '0;
        end else if (start) begin
            active <= 1'b1;
            sh_q   <= frame;
            div_q  <= '0;
            half_q <= '0;
        end else if (active) begin
            if (div_q == DIV_W'(SCLK_HALF - 1)) begin
                div_q <= '0;
                if (half_q == HALF_W'(NHALF - 1)) begin
                    active <= 1'b0;
                end else begin
                    half_q <= half_q + 1'b1;
                    if (half_q[0]) sh_q <= sh_q << 1;
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign sclk = active & half_q[0];
    assign mosi = sh_q[FRAME_BITS-1];
    assign cs_n = ~active;

    p_clk_idle_low_r6: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);
    p_mosi_hold_high_r6: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));
    p_no_restart_r11: assert property (@(posedge clk) disable iff (rst)
        start |-> !active);
endmodule

// File: rtl/dds_tune_ctrl.sv
module dds_tune_ctrl
    import dds_tune_pkg::*;
#(
    parameter int          FREQ_W        = 28,
    parameter int          REF_HZ        = 20_000_000,
    parameter int          MULT_EVEN     = 20,
    parameter int          MULT_ODD      = 19,
    parameter int          BAND_STEP_HZ  = 4_000_000,
    parameter int          HYST_HZ       = 1_000_000,
    parameter int          F_MAX_HZ      = 200_000_000,
    parameter int          SETTLE_CYCLES = 250_000,
    parameter int          SCLK_HALF     = 2,
    parameter logic [7:0]  INSTR         = 8'h04,
    localparam int         NBANDS        = F_MAX_HZ / BAND_STEP_HZ + 1,
    localparam int         BAND_W        = $clog2(NBANDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [FREQ_W-1:0] cmd_freq,
    output logic              busy,
    output logic [BAND_W-1:0] ref_band,
    output logic [7:0]        ref_mult,
    output logic              spi_sclk,
    output logic              spi_mosi,
    output logic              spi_cs_n
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);

    ctl_state_t        st_q;
    logic [BAND_W-1:0] band_q, nxt_band;
    logic [FREQ_W-1:0] cmd_q;
    logic              pend_q, change, start, spi_active, settle_done;
    logic [CNT_W-1:0]  cnt_q;
    logic [31:0]       ftw;
    spi_frame_t        frame;

    dds_band_sel #(
        .FREQ_W(FREQ_W), .BAND_W(BAND_W), .NBANDS(NBANDS),
        .STEP_HZ(BAND_STEP_HZ), .HYST_HZ(HYST_HZ)
    ) u_band (
        .freq(cmd_q), .cur_band(band_q), .nxt_band(nxt_band), .change(change)
    );

    dds_ftw_calc #(
        .FREQ_W(FREQ_W), .REF_HZ(REF_HZ),
        .MULT_EVEN(MULT_EVEN), .MULT_ODD(MULT_ODD)
    ) u_ftw (
        .freq(cmd_q), .odd_band(band_q[0]), .ftw(ftw)
    );

    assign frame       = '{instr: INSTR, ftw: ftw};
    assign start       = (st_q == ST_IDLE) && pend_q && !change;
    assign settle_done = (st_q == ST_SETTLE) && (cnt_q == '0);

    dds_spi_tx #(.SCLK_HALF(SCLK_HALF)) u_spi (
        .clk(clk), .rst(rst), .start(start), .frame(frame),
        .active(spi_active), .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            band_q <= '0;
            cmd_q  <= '0;
            pend_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            if (cmd_valid) cmd_q <= cmd_freq;
            pend_q <= cmd_valid || settle_done || (pend_q && st_q != ST_IDLE);
            case (st_q)
                ST_IDLE: begin
                    if (pend_q) begin
                        if (change) begin
                            band_q <= nxt_band;
                            cnt_q  <= CNT_W'(SETTLE_CYCLES - 1);
                            st_q   <= ST_SETTLE;
                        end else begin
                            st_q <= ST_SEND;
                        end
                    end
                end
                ST_SETTLE: begin
                    if (cnt_q == '0) st_q <= ST_IDLE;
                    else             cnt_q <= cnt_q - 1'b1;
                end
                ST_SEND: begin
                    if (!spi_active) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy     = pend_q || (st_q != ST_IDLE);
    assign ref_band = band_q;
    assign ref_mult = band_q[0] ? 8'(MULT_ODD) : 8'(MULT_EVEN);

    p_busy_after_cmd_r10: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> busy);
    p_band_moves_into_settle_r8: assert property (@(posedge clk) disable iff (rst)
        (band_q != $past(band_q)) |-> (st_q == ST_SETTLE));
    p_quiet_while_settling_r8: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SETTLE) |-> spi_cs_n);
    p_band_frozen_in_settle_r9: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SETTLE && $past(st_q) == ST_SETTLE) |-> $stable(band_q));
endmodule

// File: tb/dds_tune_ctrl_tb.sv
module dds_tune_ctrl_tb;
    localparam int FREQ_W = 28;
    localparam int REF_HZ = 20_000_000;
    localparam int M_EVEN = 20;
    localparam int M_ODD  = 19;
    localparam int STEP   = 4_000_000;
    localparam int HYST   = 1_000_000;
    localparam int FMAX   = 200_000_000;
    localparam int SETTLE = 40;
    localparam logic [7:0] INSTR = 8'h04;
    localparam int NB     = FMAX / STEP + 1;
    localparam int BW     = $clog2(NB);

    logic clk = 1'b0, rst = 1'b1, cmd_valid = 1'b0;
    logic [FREQ_W-1:0] cmd_freq = '0;
    logic busy, spi_sclk, spi_mosi, spi_cs_n;
    logic [BW-1:0] ref_band;
    logic [7:0] ref_mult;

    always #2ns clk = ~clk;

    dds_tune_ctrl #(
        .FREQ_W(FREQ_W), .REF_HZ(REF_HZ), .MULT_EVEN(M_EVEN), .MULT_ODD(M_ODD),
        .BAND_STEP_HZ(STEP), .HYST_HZ(HYST), .F_MAX_HZ(FMAX),
        .SETTLE_CYCLES(SETTLE), .SCLK_HALF(2), .INSTR(INSTR)
    ) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_freq(cmd_freq),
        .busy(busy), .ref_band(ref_band), .ref_mult(ref_mult),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
    );

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    // Serial frame capture
    logic [39:0] sh_mon = '0, last_frame = '0;
    int nbits = 0, nframes = 0;
    always @(negedge spi_cs_n) nbits = 0;
    always @(posedge spi_sclk) if (!spi_cs_n) begin
        sh_mon = {sh_mon[38:0], spi_mosi};
        nbits++;
    end
    always @(posedge spi_cs_n) if (!rst && nbits > 0) begin
        if (nbits != 40) begin
            n_tests++; n_fail++;
            $display("FAIL R6 frame length act=%0d exp=40", nbits);
        end
        last_frame = sh_mon;
        nframes++;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_ftw(input longint unsigned f, input int band);
        longint unsigned sys, k, p;
        sys = longint'(REF_HZ) * ((band % 2) ? M_ODD : M_EVEN);
        k   = ((64'd1 << 62) + sys / 2) / sys;
        p   = f * k + (64'd1 << 29);
        return 32'(p >> 30);
    endfunction

    int model_band = 0;

    function automatic int next_band(input int b, input longint f);
        longint lo, nb;
        lo = longint'(b) * STEP;
        if ((f + HYST < lo) || (f >= lo + STEP + HYST)) begin
            nb = f / STEP;
            if (nb > NB - 1) nb = NB - 1;
            return int'(nb);
        end
        return b;
    endfunction

    task automatic pulse(input longint f);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_freq  = FREQ_W'(f);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    // One command, then check latency, band, multiplier, frame and busy
    task automatic tune(input longint f, input string req);
        int n, nb, frames0;
        bit chg;
        nb  = next_band(model_band, f);
        chg = (nb != model_band);
        model_band = nb;
        frames0 = nframes;
        pulse(f);
        n = 1;
        check(busy == 1'b1, "R10", "busy after accept", busy, 1);
        while (spi_cs_n && n < 100000) begin
            @(negedge clk);
            n++;
        end
        check(n == (chg ? SETTLE + 3 : 2), chg ? "R8" : "R7", "edges to frame", n,
              chg ? SETTLE + 3 : 2);
        wait_idle();
        check(spi_cs_n == 1'b1, "R10", "busy ends after frame", spi_cs_n, 1);
        check(int'(ref_band) == nb, req, "ref_band", ref_band, nb);
        check(int'(ref_mult) == ((nb % 2) ? M_ODD : M_EVEN), "R4", "ref_mult",
              ref_mult, (nb % 2) ? M_ODD : M_EVEN);
        check(nframes == frames0 + 1, "R6", "frame count", nframes, frames0 + 1);
        check(last_frame == {INSTR, exp_ftw(f, nb)}, "R5", "frame word",
              last_frame, {INSTR, exp_ftw(f, nb)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int frames0, nb;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1", "busy", busy, 0);
        check(spi_cs_n == 1'b1, "R1", "cs_n", spi_cs_n, 1);
        check(spi_sclk == 1'b0, "R1", "sclk", spi_sclk, 0);
        check(ref_band == '0, "R1", "band", ref_band, 0);
        check(ref_mult == 8'(M_EVEN), "R1", "mult", ref_mult, M_EVEN);

        // R2 sweep across the whole range
        for (int k = 0; k < 116; k++) tune(500_000 + longint'(k) * 1_730_000, "R2");

        // R3 hysteresis edges
        tune(21_000_000, "R2");
        tune(24_999_999, "R3");
        tune(25_000_000, "R2");
        tune(23_000_000, "R3");
        tune(27_999_999, "R3");
        tune(22_999_999, "R2");
        check(ref_band == BW'(5), "R3", "band back down", ref_band, 5);
        // R2 clamp above the top band
        tune(250_000_000, "R2");
        check(ref_band == BW'(NB - 1), "R2", "clamped band", ref_band, NB - 1);
        tune(200_000_000, "R3");

        // R9 commands during settling: only the newest is sent
        frames0 = nframes;
        nb = next_band(model_band, 101_000_000);
        model_band = nb;
        pulse(101_000_000);
        repeat (5) @(negedge clk);
        pulse(101_500_000);
        repeat (5) @(negedge clk);
        pulse(102_250_000);
        wait_idle();
        check(nframes == frames0 + 1, "R9", "single frame", nframes, frames0 + 1);
        check(last_frame == {INSTR, exp_ftw(102_250_000, nb)}, "R9", "newest word",
              last_frame, {INSTR, exp_ftw(102_250_000, nb)});
        check(int'(ref_band) == nb, "R9", "band", ref_band, nb);

        // R11 command while a frame is on the wire
        frames0 = nframes;
        pulse(102_000_000);
        while (spi_cs_n) @(negedge clk);
        repeat (20) @(negedge clk);
        pulse(103_000_000);
        check(busy == 1'b1, "R11", "busy during second", busy, 1);
        wait_idle();
        check(nframes == frames0 + 2, "R11", "two frames", nframes, frames0 + 2);
        check(last_frame == {INSTR, exp_ftw(103_000_000, nb)}, "R11", "second word",
              last_frame, {INSTR, exp_ftw(103_000_000, nb)});

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule